// File: doc/BRIEF.md
# Biphasic Stimulation Pulse Sequencer

This block is the digital timing engine for a single current-stimulation channel. Once enabled, it runs a charge-balanced pulse event over and over. Each event has four parts in a fixed order: a cathodic drive phase, an optional interphase gap, an anodic drive phase of the same width, and an active charge-balancing interval. A recording-blank output brackets each event. It rises a programmable number of cycles before the cathodic phase and falls a programmable number of cycles after the balance interval. This lets the neighbouring recording amplifier reset and recover before the next event.

All timing is counted in system clock cycles. An eight-entry write-only register port holds the settings: the amplitude code, the phase width, the gap, the balance time, the blank lead and trail times, the repetition period and a burst length. These stand in for parameters loaded from a host. The amplitude code goes straight to the current DAC during the two drive phases. The direction outputs steer the H-bridge, and a separate output enables the balancing path.

Top module: `stim_seq`

## Requirements
- R1: An event runs in this order: cathodic phase, gap, anodic phase, balance interval. Both drive phases last `max(width,1)` cycles, the gap lasts `gap` cycles, and the balance interval lasts `max(bal,1)` cycles. The register addresses are 0 amplitude, 1 width, 2 gap, 3 balance, 4 blank lead, 5 blank trail, 6 period and 7 burst.
- R2: `cath_en` and `anod_en` are never high together. Both are low during the gap, the balance interval, the blank lead and trail times, and idle.
- R3: A write of amplitude 0 or above 350 leaves the stored amplitude unchanged. Codes 1 to 350 are accepted. During both drive phases `dac_code` equals the stored amplitude.
- R4: `dac_code` is 0 whenever neither drive phase is active.
- R5: A gap register of 0 removes the gap, so the anodic phase follows the cathodic phase directly.
- R6: `blank` is high for `lead` cycles before the cathodic phase, throughout the event, and for `trail` cycles after the balance interval. It is low at all other times. A value of 0 for either removes that margin.
- R7: When an event, from its first blank cycle to its last, is shorter than `period`, events start exactly `period` cycles apart. Otherwise the next event starts in the cycle right after the previous one ends.
- R8: A nonzero burst value N gives exactly N events. The block then stays idle while `enable` remains high, and a new run needs `enable` to go low and then high again. A burst value of 0 runs events until `enable` is cleared.
- R9: Clearing `enable` during an event does not cut it short. The event, including its balance interval and trail, completes before the block goes idle.
- R10: After reset all outputs are low or zero, the amplitude is 1, the width is 1 and every other register is 0.
- R11: When the block is idle and `enable` is sampled high at a clock edge, the first blank cycle (or the cathodic cycle, if the lead is 0) starts at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | DW | Register write data |
| enable | input | 1 | Run request |
| cath_en | output | 1 | H-bridge cathodic direction |
| anod_en | output | 1 | H-bridge anodic direction |
| bal_en | output | 1 | Active charge-balance path enable |
| blank | output | 1 | Recording front-end blank/reset |
| dac_code | output | AW | Current DAC amplitude code |
| busy | output | 1 | High from event start until the block returns idle |

## Verification
The assertions check the cycle-by-cycle invariants on every clock. These are: the two direction outputs are never on together, the DAC is zero outside the drive phases and always within range inside them, blank is high whenever current or balancing is active, and phase order holds at every entry into the anodic phase and into balancing. Some properties cover a window of cycles or a whole run, so only the bench scenarios can show them. These include the exact phase lengths, the lead and trail of blanking, the spacing of events against the period, the burst count and the completion of an event after `enable` is cleared. They also include the rejection of out-of-range amplitude writes. The bench scoreboard compares every output cycle against a sequence built from the register settings.

// File: rtl/stim_seq.sv
module stim_seq #(
  parameter int DW      = 16,
  parameter int AW      = 9,
  parameter int AMP_MAX = 350
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          enable,
  output logic          cath_en,
  output logic          anod_en,
  output logic          bal_en,
  output logic          blank,
  output logic [AW-1:0] dac_code,
  output logic          busy
);
  localparam int PW = DW + 4;

  typedef enum logic [2:0] {
    S_IDLE, S_LEAD, S_CATH, S_GAP, S_ANOD, S_BAL, S_TRAIL, S_WAIT
  } st_t;

  st_t           st, st_nx;
  logic [AW-1:0] r_amp;
  logic [DW-1:0] r_width, r_gap, r_bal, r_lead, r_trail, r_period, r_burst;
  logic [DW-1:0] dcnt, npulse, cur_len;
  logic [PW-1:0] pcnt;
  logic          bdone, dlast, evt_end, last_burst, per_ok, start_evt;
  st_t           first_st;

  wire [DW-1:0] w_len = (r_width == '0) ? DW'(1) : r_width;
  wire [DW-1:0] b_len = (r_bal == '0) ? DW'(1) : r_bal;
  wire          amp_ok = (cfg_wdata != '0) && (cfg_wdata <= DW'(AMP_MAX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_amp    <= AW'(1);
      r_width  <= DW'(1);
      r_gap    <= '0;
      r_bal    <= '0;
      r_lead   <= '0;
      r_trail  <= '0;
      r_period <= '0;
      r_burst  <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        3'd0: if (amp_ok) r_amp <= cfg_wdata[AW-1:0];
        3'd1: r_width  <= cfg_wdata;
        3'd2: r_gap    <= cfg_wdata;
        3'd3: r_bal    <= cfg_wdata;
        3'd4: r_lead   <= cfg_wdata;
        3'd5: r_trail  <= cfg_wdata;
        3'd6: r_period <= cfg_wdata;
        default: r_burst <= cfg_wdata;
      endcase
    end
  end

  always_comb begin
    case (st)
      S_LEAD:          cur_len = r_lead;
      S_CATH, S_ANOD:  cur_len = w_len;
      S_GAP:           cur_len = r_gap;
      S_BAL:           cur_len = b_len;
      S_TRAIL:         cur_len = r_trail;
      default:         cur_len = DW'(1);
    endcase
  end

  assign dlast      = (dcnt == cur_len - DW'(1));
  assign first_st   = (r_lead != '0) ? S_LEAD : S_CATH;
  assign per_ok     = (pcnt + PW'(1)) >= PW'(r_period);
  assign evt_end    = dlast && ((st == S_BAL && r_trail == '0) || st == S_TRAIL);
  assign last_burst = (r_burst != '0) && ((npulse + DW'(1)) >= r_burst);

  always_comb begin
    st_nx     = st;
    start_evt = 1'b0;
    case (st)
      S_IDLE:
        if (enable && !bdone) begin
          st_nx     = first_st;
          start_evt = 1'b1;
        end
      S_LEAD: if (dlast) st_nx = S_CATH;
      S_CATH: if (dlast) st_nx = (r_gap != '0) ? S_GAP : S_ANOD;
      S_GAP:  if (dlast) st_nx = S_ANOD;
      S_ANOD: if (dlast) st_nx = S_BAL;
      S_BAL:  if (dlast && r_trail != '0) st_nx = S_TRAIL;
      S_WAIT:
        if (!enable) st_nx = S_IDLE;
        else if (per_ok) begin
          st_nx     = first_st;
          start_evt = 1'b1;
        end
      default: ;
    endcase
    if (evt_end) begin
      if (!enable || last_burst) st_nx = S_IDLE;
      else if (per_ok) begin
        st_nx     = first_st;
        start_evt = 1'b1;
      end else st_nx = S_WAIT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      dcnt   <= '0;
      pcnt   <= '0;
      npulse <= '0;
      bdone  <= 1'b0;
    end else begin
      st   <= st_nx;
      dcnt <= (st_nx != st || evt_end) ? '0 : dcnt + DW'(1);
      if (start_evt)     pcnt <= '0;
      else if (~&pcnt)   pcnt <= pcnt + PW'(1);
      if (st == S_IDLE)  npulse <= '0;
      else if (evt_end)  npulse <= npulse + DW'(1);
      if (!enable)       bdone <= 1'b0;
      else if (evt_end && last_burst) bdone <= 1'b1;
    end
  end

  assign cath_en  = (st == S_CATH);
  assign anod_en  = (st == S_ANOD);
  assign bal_en   = (st == S_BAL);
  assign blank    = (st != S_IDLE) && (st != S_WAIT);
  assign dac_code = (cath_en || anod_en) ? r_amp : '0;
  assign busy     = (st != S_IDLE);
endmodule

// File: rtl/stim_seq_chk.sv
module stim_seq_chk #(
  parameter int AW      = 9,
  parameter int AMP_MAX = 350
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cath_en,
  input logic          anod_en,
  input logic          bal_en,
  input logic          blank,
  input logic [AW-1:0] dac_code
);
  p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cath_en && anod_en));

  p_dac_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cath_en || anod_en) |-> dac_code == '0);

  p_dac_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cath_en || anod_en) |-> (dac_code != '0 && dac_code <= AW'(AMP_MAX)));

  p_blank_cover_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cath_en || anod_en || bal_en) |-> blank);

  p_bal_after_anod_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bal_en) |-> $past(anod_en));

  p_anod_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(anod_en) |-> ($past(blank) && !$past(bal_en)));
endmodule

bind stim_seq stim_seq_chk #(.AW(AW), .AMP_MAX(AMP_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .cath_en(cath_en), .anod_en(anod_en),
  .bal_en(bal_en), .blank(blank), .dac_code(dac_code)
);

// File: tb/stim_seq_test.sv
module stim_seq_test;
  localparam int DW = 16;
  localparam int AW = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic          enable = 1'b0;
  logic          cath_en, anod_en, bal_en, blank, busy;
  logic [AW-1:0] dac_code;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  logic [12:0] expq[$];

  int c_lead, c_width, c_gap, c_bal, c_trail, c_period, c_amp;

  always #5 clk = ~clk;

  stim_seq #(.DW(DW), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .enable(enable), .cath_en(cath_en),
    .anod_en(anod_en), .bal_en(bal_en), .blank(blank),
    .dac_code(dac_code), .busy(busy)
  );

  // scoreboard monitor: samples 1 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expq.size() > 0) begin
        logic [12:0] e;
        logic [12:0] a;
        e = expq.pop_front();
        a = {cath_en, anod_en, bal_en, blank, dac_code};
        tests++;
        if (a != e) begin
          fails++;
          if (a[12:11] != e[12:11])
            $display("FAIL R1/R2 direction: got cath=%0b anod=%0b exp cath=%0b anod=%0b at %0t",
                     a[12], a[11], e[12], e[11], $time);
          if (a[10] != e[10])
            $display("FAIL R1 balance: got %0b exp %0b at %0t", a[10], e[10], $time);
          if (a[9] != e[9])
            $display("FAIL R6/R7 blank: got %0b exp %0b at %0t", a[9], e[9], $time);
          if (a[8:0] != e[8:0])
            $display("FAIL R3/R4 dac: got %0d exp %0d at %0t", a[8:0], e[8:0], $time);
        end
      end
    end
  end

  task automatic wr(input int addr, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(addr); cfg_wdata = DW'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input int ld, input int w, input int g, input int b,
                       input int tr, input int per, input int burst);
    c_lead = ld; c_width = w; c_gap = g; c_bal = b; c_trail = tr; c_period = per;
    wr(1, w); wr(2, g); wr(3, b); wr(4, ld); wr(5, tr); wr(6, per); wr(7, burst);
  endtask

  task automatic push_n(input int n, input logic [12:0] item);
    for (int i = 0; i < n; i++) expq.push_back(item);
  endtask

  // expected sequence for npulse events followed by tail idle cycles
  task automatic push_events(input int npulse, input int tail);
    int w, b, len;
    w = (c_width == 0) ? 1 : c_width;
    b = (c_bal == 0) ? 1 : c_bal;
    len = c_lead + w + c_gap + w + b + c_trail;
    for (int p = 0; p < npulse; p++) begin
      push_n(c_lead,  {4'b0001, 9'd0});
      push_n(w,       {4'b1001, 9'(c_amp)});
      push_n(c_gap,   {4'b0001, 9'd0});
      push_n(w,       {4'b0101, 9'(c_amp)});
      push_n(b,       {4'b0011, 9'd0});
      push_n(c_trail, {4'b0001, 9'd0});
      if (p < npulse - 1 && c_period > len) push_n(c_period - len, 13'd0);
    end
    push_n(tail, 13'd0);
  endtask

  // drive: enable and push expectations at the same falling edge (R11)
  task automatic run(input int npulse, input int drop_after);
    @(negedge clk);
    enable = 1'b1;
    push_events(npulse, 20);
    if (drop_after > 0) begin
      repeat (drop_after) @(negedge clk);
      enable = 1'b0;
    end
    wait (expq.size() == 0);
    @(negedge clk);
    enable = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tests++;
    if ({cath_en, anod_en, bal_en, blank, busy} != 5'b0 || dac_code != 0) begin
      fails++;
      $display("FAIL R10 reset outputs: got %b/%0d exp 00000/0",
               {cath_en, anod_en, bal_en, blank, busy}, dac_code);
    end

    // R1 R6 R7 R8: lead 2, width 3, gap 2, bal 2, trail 3, period 30, burst 2
    c_amp = 100; wr(0, 100);
    setup(2, 3, 2, 2, 3, 30, 2);
    run(2, 0);

    // R3 R5: rejected amplitude writes, zero gap/lead/trail, zero width/bal
    c_amp = 350; wr(0, 350); wr(0, 0); wr(0, 351); wr(0, 512);
    setup(0, 0, 0, 0, 0, 5, 3);
    run(3, 0);

    // R3 lowest code, R7 back-to-back when event longer than period
    c_amp = 1; wr(0, 1);
    setup(1, 2, 1, 1, 1, 4, 2);
    run(2, 0);

    // R8 continuous burst, R9 enable cleared inside third event
    c_amp = 77; wr(0, 77);
    setup(2, 3, 2, 2, 3, 30, 0);
    run(3, 61);

    // R9 enable cleared during the very first cathodic cycle
    setup(0, 4, 1, 3, 2, 20, 0);
    run(1, 1);

    tests++;
    if (busy !== 1'b0) begin
      fails++;
      $display("FAIL R8 busy after stop: got %0b exp 0", busy);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired: got hang exp completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule